// File: doc/BRIEF.md
# Dual-Cell Hit Delay Noise Filter

This block sits behind one discriminator channel. It turns each accepted hit into a short pulse that appears a fixed number of clock cycles later. The delay gives the trigger logic time to decide, so the delayed bit can be sampled when the trigger arrives. All timing comes from counters, so no analog one-shots are involved and component tolerance plays no part. The hit input is asynchronous. It passes through a flop synchronizer, and a rising-edge detector turns each new hit into a one-cycle start event.

Two delay cells share the channel. The "first" cell is non-retriggerable: once it starts, further hits cannot move its timing, so it reproduces the earliest hit of a window. The "last" cell is retriggerable: every start it receives restarts its delay, so it reproduces the latest hit. A start goes to the first cell when that cell is idle and to the last cell otherwise. The channel output is the OR of the two cells' pulses. A lone non-retriggerable cell would leave the channel dead for the full delay plus the pulse. With the second cell beside it, hits that arrive during that span are still reproduced.

Each cell is a state machine with three states: `ST_IDLE`, `ST_DELAY` and `ST_PULSE`. The transitions are:
- IDLE→DELAY on a start (the counter is cleared).
- DELAY→DELAY with a counter clear on a start, in the retriggerable cell only.
- DELAY→PULSE when the delay count reaches `DELAY_CYC-1`.
- PULSE→IDLE when the width count reaches `PULSE_CYC-1`.
- Any state→IDLE on reset.

Top module: `hit_delay_filter`

## Requirements
- R1: While `rst_n` is low, and from then until the first hit, `pulse_o`, `first_busy_o` and `last_busy_o` are 0. Asserting reset during a delay cancels the pending pulse.
- R2: If `hit_i` is first sampled high at clock edge n while both cells are idle, `pulse_o` is 1 after edges n+DELAY_CYC+2 through n+DELAY_CYC+PULSE_CYC+1 and 0 just before and just after. With the defaults (64, 4), it is high for the 4 cycles that start 66 edges after n.
- R3: The first cell is non-retriggerable. Hits arriving while it is busy do not shift or lengthen its pulse.
- R4: The last cell is retriggerable. Each start it receives restarts its full delay, so of several hits routed to it within one delay, only the last one produces a pulse.
- R5: A new hit (a rising edge after synchronization) starts the first cell when `first_busy_o` is 0, and otherwise starts only the last cell.
- R6: `pulse_o` is the OR of both cells' pulses. Two hits routed to different cells give two pulses, each at its own R2 latency.
- R7: A hit arriving while the first cell is emitting its pulse is still reproduced, through the last cell, at its own R2 latency.
- R8: `first_busy_o` (or `last_busy_o`) is 1 from the edge on which its cell leaves ST_IDLE through the last edge of its pulse, which is edges n+2 through n+DELAY_CYC+PULSE_CYC+1 for a hit sampled at edge n.
- R9: A hit held high for many cycles counts as one hit. It produces one pulse and never starts the last cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 1 | Asynchronous discriminator hit |
| pulse_o | output | 1 | Delayed data pulse (OR of both cells) |
| first_busy_o | output | 1 | Non-retriggerable cell is not idle |
| last_busy_o | output | 1 | Retriggerable cell is not idle |

## Verification
The assertions check the following on every cycle:
- The counters stay within their limits.
- A pulse starts only from the delay state.
- The first cell counts steadily through its delay, whatever arrives at its start input.
- A start restarts the last cell.
- A start reaching an idle first cell makes it busy.
- The output is never high while both cells are idle.

Only the bench's scenarios can show the things that depend on whole stories of hits: the exact latency and width of the pulse, which of several hits in a window survives, the short deadtime around the first cell's pulse, the single event from a long hit, and the cancellation on reset.

// File: rtl/hdf_pkg.sv
package hdf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_PULSE = 2'd2
    } cell_state_e;
endpackage

// File: rtl/hdf_sync.sv
module hdf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R9
endmodule

// File: rtl/hdf_cell.sv
module hdf_cell
    import hdf_pkg::*;
#(
    parameter int DELAY_CYC = 64,
    parameter int PULSE_CYC = 4,
    parameter bit RETRIG    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic pulse_o
);
    localparam int MAXC = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] DLY_LAST = CW'(DELAY_CYC - 1);
    localparam logic [CW-1:0] WID_LAST = CW'(PULSE_CYC - 1);

    cell_state_e    state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_DELAY;
                    cnt_d   = '0;
                end
            end
            ST_DELAY: begin
                if (RETRIG && start_i) begin
                    cnt_d = '0;
                end else if (cnt_q == DLY_LAST) begin
                    state_d = ST_PULSE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_PULSE: begin
                if (cnt_q == WID_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        busy_o  = (state_q != ST_IDLE);
        pulse_o = (state_q == ST_PULSE);
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE) |-> (cnt_q <= WID_LAST)); // R2
    AST_PULSE_FROM_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> ($past(state_q) == ST_DELAY)); // R2

    generate
        if (RETRIG) begin : g_retrig
            AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == ST_DELAY && start_i) |=> (state_q == ST_DELAY && cnt_q == '0)); // R4
        end else begin : g_noretrig
            AST_STEADY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == ST_DELAY && cnt_q != DLY_LAST) |=>
                (state_q == ST_DELAY && cnt_q == $past(cnt_q) + 1'b1)); // R3
        end
    endgenerate
endmodule

// File: rtl/hit_delay_filter.sv
module hit_delay_filter #(
    parameter int DELAY_CYC   = 64,
    parameter int PULSE_CYC   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic pulse_o,
    output logic first_busy_o,
    output logic last_busy_o
);
    logic rise_w;
    logic first_start, last_start;
    logic first_pulse, last_pulse;

    hdf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(hit_i),
        .rise_o (rise_w)
    );

    assign first_start = rise_w & ~first_busy_o;
    assign last_start  = rise_w &  first_busy_o;

    hdf_cell #(.DELAY_CYC(DELAY_CYC), .PULSE_CYC(PULSE_CYC), .RETRIG(1'b0)) u_first (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(first_start),
        .busy_o (first_busy_o),
        .pulse_o(first_pulse)
    );

    hdf_cell #(.DELAY_CYC(DELAY_CYC), .PULSE_CYC(PULSE_CYC), .RETRIG(1'b1)) u_last (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(last_start),
        .busy_o (last_busy_o),
        .pulse_o(last_pulse)
    );

    assign pulse_o = first_pulse | last_pulse;

    AST_IDLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_w && !first_busy_o) |=> first_busy_o); // R5
    AST_NO_IDLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> (first_busy_o || last_busy_o)); // R6
endmodule

// File: tb/hit_delay_filter_tb_top.sv
`timescale 1ns/1ps
module hit_delay_filter_tb_top;
    localparam int DLY = 64;
    localparam int WID = 4;
    localparam int LAT = DLY + 3;
    localparam int TMAX = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hit_i = 1'b0;
    logic pulse_o, first_busy_o, last_busy_o;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    logic tr_p  [0:TMAX-1];
    logic tr_b1 [0:TMAX-1];
    logic tr_b2 [0:TMAX-1];

    always #2.5 clk = ~clk;

    hit_delay_filter #(.DELAY_CYC(DLY), .PULSE_CYC(WID), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i),
        .pulse_o(pulse_o), .first_busy_o(first_busy_o), .last_busy_o(last_busy_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cyc < TMAX) begin
            tr_p[cyc]  = pulse_o;
            tr_b1[cyc] = first_busy_o;
            tr_b2[cyc] = last_busy_o;
        end
    end

    // sel: 0 pulse_o, 1 first_busy_o, 2 last_busy_o
    task automatic chk(input int sel, input int lo, input int hi, input logic exp, input string req);
        logic got;
        bit bad = 0;
        n_run++;
        for (int t = lo; t <= hi; t++) begin
            got = (sel == 0) ? tr_p[t] : (sel == 1) ? tr_b1[t] : tr_b2[t];
            if (!bad && got !== exp) begin
                bad = 1;
                $display("FAIL %s sig%0d cycle %0d: actual %b expected %b", req, sel, t, got, exp);
            end
        end
        if (bad) n_fail++;
    endtask

    task automatic hit_now(output int h);
        @(negedge clk);
        h = cyc;
        hit_i = 1'b1;
        @(negedge clk);
        hit_i = 1'b0;
    endtask

    task automatic hit_at(input int t, output int h);
        while (cyc < t - 1) @(negedge clk);
        hit_now(h);
    endtask

    task automatic settle(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic t_reset;
        settle(3);
        chk(0, 1, 3, 1'b0, "R1 reset pulse");
        chk(1, 1, 3, 1'b0, "R1 reset busy1");
        chk(2, 1, 3, 1'b0, "R1 reset busy2");
    endtask

    task automatic t_single;
        int h;
        hit_now(h);
        settle(h + LAT + WID + 4);
        chk(0, h, h + LAT - 1, 1'b0, "R2 before pulse");
        chk(0, h + LAT, h + LAT + WID - 1, 1'b1, "R2 pulse");
        chk(0, h + LAT + WID, h + LAT + WID + 2, 1'b0, "R2 after pulse");
        chk(1, h + 3, h + LAT + WID - 1, 1'b1, "R8 busy1 span");
        chk(1, h + LAT + WID, h + LAT + WID + 2, 1'b0, "R8 busy1 end");
        chk(2, h, h + LAT + WID, 1'b0, "R5 last idle");
    endtask

    task automatic t_two;
        int a, b;
        hit_now(a);
        hit_at(a + 10, b);
        settle(b + LAT + WID + 3);
        chk(0, a + LAT, a + LAT + WID - 1, 1'b1, "R6 first pulse");
        chk(0, a + LAT + WID, b + LAT - 1, 1'b0, "R6 gap");
        chk(0, b + LAT, b + LAT + WID - 1, 1'b1, "R6 second pulse");
        chk(2, b + 3, b + LAT + WID - 1, 1'b1, "R5 routed to last");
    endtask

    task automatic t_three;
        int a, b, c;
        hit_now(a);
        hit_at(a + 10, b);
        hit_at(a + 20, c);
        settle(c + LAT + WID + 3);
        chk(0, a + LAT, a + LAT + WID - 1, 1'b1, "R3 first kept");
        chk(0, a + LAT + WID, c + LAT - 1, 1'b0, "R4 middle dropped");
        chk(0, c + LAT, c + LAT + WID - 1, 1'b1, "R4 last kept");
        chk(0, c + LAT + WID, c + LAT + WID + 2, 1'b0, "R3 no stretch");
    endtask

    task automatic t_dead;
        int a, b;
        hit_now(a);
        hit_at(a + 66, b);
        settle(b + LAT + WID + 3);
        chk(0, a + LAT, a + LAT + WID - 1, 1'b1, "R7 first pulse");
        chk(0, b + LAT, b + LAT + WID - 1, 1'b1, "R7 hit in pulse kept");
    endtask

    task automatic t_long;
        int h;
        @(negedge clk);
        h = cyc;
        hit_i = 1'b1;
        repeat (20) @(negedge clk);
        hit_i = 1'b0;
        settle(h + LAT + WID + 30);
        chk(0, h + LAT, h + LAT + WID - 1, 1'b1, "R9 one pulse");
        chk(0, h + LAT + WID, h + LAT + WID + 29, 1'b0, "R9 no extra");
        chk(2, h, h + LAT + WID + 29, 1'b0, "R9 last never started");
    endtask

    task automatic t_midreset;
        int h;
        hit_now(h);
        settle(h + 30);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        settle(h + LAT + WID + 5);
        chk(1, h + 32, h + LAT + WID + 4, 1'b0, "R1 reset cancels busy");
        chk(0, h + 32, h + LAT + WID + 4, 1'b0, "R1 reset cancels pulse");
    endtask

    task automatic finish_up;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        settle(10);
        t_single();
        settle(cyc + 10);
        t_two();
        settle(cyc + 10);
        t_three();
        settle(cyc + 10);
        t_dead();
        settle(cyc + 10);
        t_long();
        settle(cyc + 10);
        t_midreset();
        finish_up();
    end
endmodule